// File: doc/BRIEF.md
# Reset Sequencer with Strap Capture

This block turns a raw reset request into a clean internal reset. It keeps that reset asserted for a minimum number of clock cycles. The minimum depends on the kind of reset. A cold reset starts when the power-good input goes low. A warm reset starts when the raw request is asserted while power is already good. A request that is released too early is stretched internally, so the internal reset still lasts the full minimum. Both minimums are parameters counted in clock cycles.

On the clock edge that ends the internal reset, the block latches three things: a multi-bit clock-ratio strap, a burst-ready strap and a flush request. The flush request is taken from the edge before the release, which matches a synchronous driver. Stability is checked around the release edge:
- The five strap bits must be steady over the release edge and the edges just before it.
- The straps must then stay equal to the latched values for a short hold window after it.

Any breach sets a sticky violation flag. The latched values are kept in that case. They stay constant until the next reset assertion clears them.

Top module: `rst_seq_top`

## Requirements
- R1: Power-good low forces the following, asynchronously: `core_rst`=1, all latched outputs 0, `strap_viol`=0, and the reset is marked cold. Sampling `rst_req`=1 on an edge while `core_rst`=0 sets `core_rst`=1 and clears `ratio_cfg`, `burst_cfg` and `flush_cfg` to 0 after that edge.
- R2: On each edge where `core_rst` is 1, let E be that edge's count: counting starts at 1 on the first edge after power-good rises (cold), or on the first edge after the asserting edge (warm). `core_rst` falls after the first edge with `rst_req`=0 and E >= the active minimum. While `rst_req` is 1, `core_rst` stays 1.
- R3: The active minimum is COLD_MIN (default 64) for a cold reset and WARM_MIN (default 15) for a warm reset.
- R4: If `rst_req` drops before the minimum is reached, the internal reset is extended until the edge where E equals the minimum.
- R5: `ratio_cfg` and `burst_cfg` take the values of `ratio_strap` and `burst_strap` sampled on the release edge.
- R6: `flush_cfg` takes the value of `flush_req` sampled on the edge immediately before the release edge.
- R7: The latched outputs do not change while `core_rst` stays 0.
- R8: On each of the HOLD_CYC (default 2) edges after the release edge, the 5-bit vector {flush_req, burst_strap, ratio_strap} is compared with the latched values. A difference sets `strap_viol`, and the latched values are left unchanged.
- R9: On the release edge, `strap_viol` is set if the 5-bit strap vector differs between any two of the release edge and the SETUP_CYC (default 2) edges before it. The capture still takes place.
- R10: `strap_viol` is sticky. Only power-good low clears it.
- R11: If `rst_req` is sampled as 1 on an edge inside the hold window, that edge starts a new reset. No window comparison is made on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| pwr_good | input | 1 | Supply/clock good; low is an asynchronous cold reset |
| rst_req | input | 1 | Raw reset request, active high |
| ratio_strap | input | RATIO_W | Clock-ratio strap |
| burst_strap | input | 1 | Secondary burst-ready strap |
| flush_req | input | 1 | Flush request sampled around reset release |
| core_rst | output | 1 | Internal reset, active high |
| ratio_cfg | output | RATIO_W | Latched clock ratio |
| burst_cfg | output | 1 | Latched burst-ready strap |
| flush_cfg | output | 1 | Latched flush-at-reset flag |
| strap_viol | output | 1 | Sticky strap timing violation |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is the release edge, which both captures the straps and runs the stability check on the edges before it. The bench drops `rst_req` and toggles `flush_req` on the same half-cycle. It then expects `flush_cfg` to keep the older flush value while `strap_viol` rises.

The second pair is a hold-window edge that also sees a new reset request. The bench asserts `rst_req` and changes `ratio_strap` together on the first window edge. It expects a fresh reset with cleared outputs and no violation.

A behavioural model with a history queue predicts every output on every clock.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
    typedef enum logic {
        PH_HOLD = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;
endpackage

// File: rtl/rst_width_ctrl.sv
module rst_width_ctrl
    import rst_seq_pkg::*;
#(
    parameter int COLD_MIN = 64,
    parameter int WARM_MIN = 15
) (
    input  logic clk,
    input  logic pwr_good,
    input  logic rst_req,
    output logic core_rst,
    output logic release_o,
    output logic assert_o
);
    localparam int MAX_MIN = (COLD_MIN > WARM_MIN) ? COLD_MIN : WARM_MIN;
    localparam int CNT_W   = (MAX_MIN < 2) ? 1 : $clog2(MAX_MIN);
    localparam logic [CNT_W-1:0] COLD_LIM = CNT_W'(COLD_MIN - 1);
    localparam logic [CNT_W-1:0] WARM_LIM = CNT_W'(WARM_MIN - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             cold;
    } wc_state_t;

    wc_state_t s_d, s_q;
    logic [CNT_W-1:0] lim;

    always_comb begin
        s_d       = s_q;
        release_o = 1'b0;
        assert_o  = 1'b0;
        lim       = s_q.cold ? COLD_LIM : WARM_LIM;
        if (s_q.phase == PH_HOLD) begin
            if (!rst_req && (s_q.cnt >= lim)) begin
                s_d.phase = PH_RUN;
                s_d.cold  = 1'b0;
                s_d.cnt   = '0;
                release_o = 1'b1;
            end else if (s_q.cnt < lim) begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else if (rst_req) begin
            s_d.phase = PH_HOLD;
            s_d.cnt   = '0;
            assert_o  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) begin
            s_q <= '{phase: PH_HOLD, cnt: '0, cold: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign core_rst = (s_q.phase == PH_HOLD);

    p_enter_on_req_r1: assert property (@(posedge clk) disable iff (!pwr_good)
        (!core_rst && rst_req) |=> core_rst);

    p_hold_while_req_r2: assert property (@(posedge clk) disable iff (!pwr_good)
        (core_rst && rst_req) |=> core_rst);
endmodule

// File: rtl/strap_capture.sv
module strap_capture #(
    parameter int RATIO_W   = 3,
    parameter int HOLD_CYC  = 2,
    parameter int SETUP_CYC = 2
) (
    input  logic               clk,
    input  logic               pwr_good,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               burst_i,
    input  logic               flush_i,
    input  logic               release_i,
    input  logic               assert_i,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               burst_o,
    output logic               flush_o,
    output logic               viol_o
);
    localparam int SW    = RATIO_W + 2;
    localparam int WIN_W = $clog2(HOLD_CYC + 1);
    localparam logic [WIN_W-1:0] WIN_INIT = WIN_W'(HOLD_CYC);

    typedef struct packed {
        logic [SW-1:0]                 capt;
        logic [WIN_W-1:0]              win;
        logic                          viol;
        logic [SETUP_CYC-1:0][SW-1:0]  hist;
    } cap_state_t;

    cap_state_t s_d, s_q;
    logic [SW-1:0]        cur;
    logic [SETUP_CYC-1:0] unstable;

    assign cur = {flush_i, burst_i, ratio_i};

    // Stability across the release edge and the edges before it
    assign unstable[0] = (cur != s_q.hist[0]);
    for (genvar k = 1; k < SETUP_CYC; k++) begin : g_setup
        assign unstable[k] = (s_q.hist[k-1] != s_q.hist[k]);
    end

    always_comb begin
        s_d         = s_q;
        s_d.hist[0] = cur;
        for (int k = 1; k < SETUP_CYC; k++) begin
            s_d.hist[k] = s_q.hist[k-1];
        end
        if (assert_i) begin
            s_d.capt = '0;
            s_d.win  = '0;
        end else if (release_i) begin
            s_d.capt = {s_q.hist[0][SW-1], cur[SW-2:0]};
            s_d.win  = WIN_INIT;
            if (|unstable) begin
                s_d.viol = 1'b1;
            end
        end else if (s_q.win != '0) begin
            s_d.win = s_q.win - 1'b1;
            if (cur != s_q.capt) begin
                s_d.viol = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ratio_o = s_q.capt[RATIO_W-1:0];
    assign burst_o = s_q.capt[SW-2];
    assign flush_o = s_q.capt[SW-1];
    assign viol_o  = s_q.viol;

    p_ratio_at_release_r5: assert property (@(posedge clk) disable iff (!pwr_good)
        release_i |=> (ratio_o == $past(ratio_i)) && (burst_o == $past(burst_i)));

    p_window_change_r8: assert property (@(posedge clk) disable iff (!pwr_good)
        (s_q.win != '0 && !assert_i && !release_i && cur != s_q.capt) |=> viol_o);

    p_viol_sticky_r10: assert property (@(posedge clk) disable iff (!pwr_good)
        viol_o |=> viol_o);
endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top #(
    parameter int COLD_MIN  = 64,
    parameter int WARM_MIN  = 15,
    parameter int RATIO_W   = 3,
    parameter int HOLD_CYC  = 2,
    parameter int SETUP_CYC = 2
) (
    input  logic               clk,
    input  logic               pwr_good,
    input  logic               rst_req,
    input  logic [RATIO_W-1:0] ratio_strap,
    input  logic               burst_strap,
    input  logic               flush_req,
    output logic               core_rst,
    output logic [RATIO_W-1:0] ratio_cfg,
    output logic               burst_cfg,
    output logic               flush_cfg,
    output logic               strap_viol
);
    logic rel_pulse;
    logic asr_pulse;

    rst_width_ctrl #(
        .COLD_MIN (COLD_MIN),
        .WARM_MIN (WARM_MIN)
    ) u_width (
        .clk       (clk),
        .pwr_good  (pwr_good),
        .rst_req   (rst_req),
        .core_rst  (core_rst),
        .release_o (rel_pulse),
        .assert_o  (asr_pulse)
    );

    strap_capture #(
        .RATIO_W   (RATIO_W),
        .HOLD_CYC  (HOLD_CYC),
        .SETUP_CYC (SETUP_CYC)
    ) u_capture (
        .clk       (clk),
        .pwr_good  (pwr_good),
        .ratio_i   (ratio_strap),
        .burst_i   (burst_strap),
        .flush_i   (flush_req),
        .release_i (rel_pulse),
        .assert_i  (asr_pulse),
        .ratio_o   (ratio_cfg),
        .burst_o   (burst_cfg),
        .flush_o   (flush_cfg),
        .viol_o    (strap_viol)
    );

    // Independent width measurement used only by the checks below
    int unsigned hi_cnt_q;
    logic        cold_mark_q;

    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) begin
            hi_cnt_q    <= 0;
            cold_mark_q <= 1'b1;
        end else begin
            hi_cnt_q    <= core_rst ? hi_cnt_q + 1 : 0;
            cold_mark_q <= core_rst ? cold_mark_q : 1'b0;
        end
    end

    p_min_width_r3: assert property (@(posedge clk) disable iff (!pwr_good)
        $fell(core_rst) |-> (hi_cnt_q >= (cold_mark_q ? COLD_MIN : WARM_MIN)));

    p_cfg_stable_r7: assert property (@(posedge clk) disable iff (!pwr_good)
        (!core_rst && !rst_req) |=> $stable(ratio_cfg) && $stable(burst_cfg) && $stable(flush_cfg));
endmodule

// File: tb/rst_seq_top_tb_top.sv
module rst_seq_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int COLD = 40;
    localparam int WARM = 15;

    logic       clk = 1'b0;
    logic       pwr_good = 1'b0;
    logic       rst_req = 1'b1;
    logic [2:0] ratio_strap = 3'd5;
    logic       burst_strap = 1'b1;
    logic       flush_req = 1'b1;
    logic       core_rst;
    logic [2:0] ratio_cfg;
    logic       burst_cfg;
    logic       flush_cfg;
    logic       strap_viol;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rst_seq_top #(.COLD_MIN(COLD), .WARM_MIN(WARM)) dut_i (
        .clk(clk), .pwr_good(pwr_good), .rst_req(rst_req),
        .ratio_strap(ratio_strap), .burst_strap(burst_strap), .flush_req(flush_req),
        .core_rst(core_rst), .ratio_cfg(ratio_cfg), .burst_cfg(burst_cfg),
        .flush_cfg(flush_cfg), .strap_viol(strap_viol)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    bit       m_rst, m_cold, m_viol;
    int       m_age, m_win;
    bit [4:0] m_cap;
    bit [4:0] hist[$];

    always @(posedge clk or negedge pwr_good) begin
        bit [4:0] cur;
        int lim;
        if (!pwr_good) begin
            m_rst = 1; m_age = 0; m_cold = 1; m_cap = 0; m_viol = 0; m_win = 0;
            hist = {5'd0, 5'd0};
        end else begin
            cur = {flush_req, burst_strap, ratio_strap};
            lim = m_cold ? COLD : WARM;
            if (m_rst) begin
                if (!rst_req && m_age + 1 >= lim) begin
                    m_rst = 0; m_cold = 0;
                    m_cap = {hist[0][4], cur[3:0]};
                    if (cur != hist[0] || hist[0] != hist[1]) m_viol = 1;
                    m_win = 2;
                end else m_age++;
            end else if (rst_req) begin
                m_rst = 1; m_age = 0; m_cap = 0; m_win = 0;
            end else if (m_win > 0) begin
                if (cur != m_cap) m_viol = 1;
                m_win--;
            end
            hist.push_front(cur);
            void'(hist.pop_back());
        end
    end

    always @(negedge clk) begin
        check(core_rst == m_rst, "R2 core_rst", int'(core_rst), int'(m_rst));
        check(ratio_cfg == m_cap[2:0], "R5 ratio_cfg", int'(ratio_cfg), int'(m_cap[2:0]));
        check(burst_cfg == m_cap[3], "R5 burst_cfg", int'(burst_cfg), int'(m_cap[3]));
        check(flush_cfg == m_cap[4], "R6 flush_cfg", int'(flush_cfg), int'(m_cap[4]));
        check(strap_viol == m_viol, "R8 strap_viol", int'(strap_viol), int'(m_viol));
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wait_release(inout int e);
        do begin
            @(negedge clk);
            e++;
        end while (core_rst);
        #1;
    endtask

    task automatic warm(input int k, output int e);
        rst_req = 1'b1;
        step(1);
        check(core_rst == 1'b1 && ratio_cfg == 3'd0 && flush_cfg == 1'b0, "R1 warm entry",
              int'(core_rst), 1);
        e = 0;
        repeat (k - 1) begin @(negedge clk); e++; #1; end
        rst_req = 1'b0;
        wait_release(e);
    endtask

    task automatic cold(input int k, output int e);
        pwr_good = 1'b1;
        e = 0;
        repeat (k) begin @(negedge clk); e++; #1; end
        rst_req = 1'b0;
        wait_release(e);
    endtask

    initial begin
        int e;
        step(3);
        check(core_rst == 1'b1 && ratio_cfg == 0 && strap_viol == 0, "R1 power-good low",
              int'(core_rst), 1);
        // Cold reset, request released early
        cold(5, e);
        check(e == COLD, "R3 cold width", e, COLD);
        check(ratio_cfg == 3'd5 && burst_cfg && flush_cfg, "R5 cold capture", int'(ratio_cfg), 5);
        // Warm, long request
        ratio_strap = 3'd3; burst_strap = 1'b0; flush_req = 1'b0;
        step(4);
        warm(20, e);
        check(e == 20, "R2 warm long width", e, 20);
        check(ratio_cfg == 3'd3 && !burst_cfg && !flush_cfg, "R5 warm capture", int'(ratio_cfg), 3);
        // Warm, request released early: stretched
        warm(2, e);
        check(e == WARM, "R4 early release stretched", e, WARM);
        // Change inside hold window
        ratio_strap = 3'd6;
        step(1);
        check(strap_viol == 1'b1, "R8 window change flag", int'(strap_viol), 1);
        check(ratio_cfg == 3'd3, "R8 capture kept", int'(ratio_cfg), 3);
        step(2);
        // Sticky across warm reset
        warm(16, e);
        check(strap_viol == 1'b1, "R10 sticky", int'(strap_viol), 1);
        check(ratio_cfg == 3'd6, "R5 new capture", int'(ratio_cfg), 6);
        // Power-good low clears
        pwr_good = 1'b0; rst_req = 1'b1;
        #1;
        check(strap_viol == 1'b0 && core_rst == 1'b1, "R10 cleared by power-good", int'(strap_viol), 0);
        ratio_strap = 3'd2;
        step(2);
        cold(3, e);
        check(e == COLD, "R3 second cold width", e, COLD);
        check(strap_viol == 1'b0, "R9 stable straps no flag", int'(strap_viol), 0);
        // Flush toggles on the release edge
        rst_req = 1'b1;
        step(20);
        rst_req = 1'b0; flush_req = 1'b1;
        step(1);
        check(core_rst == 1'b0, "R2 release at edge 20", int'(core_rst), 0);
        check(flush_cfg == 1'b0, "R6 flush from prior edge", int'(flush_cfg), 0);
        check(strap_viol == 1'b1, "R9 pre-release change", int'(strap_viol), 1);
        // Reassertion inside window
        pwr_good = 1'b0;
        step(2);
        pwr_good = 1'b1;
        e = 0;
        wait_release(e);
        check(flush_cfg == 1'b1 && strap_viol == 1'b0, "R6 cold flush capture", int'(flush_cfg), 1);
        rst_req = 1'b1; ratio_strap = 3'd7;
        step(1);
        check(core_rst == 1'b1 && ratio_cfg == 3'd0, "R11 reassert in window", int'(core_rst), 1);
        check(strap_viol == 1'b0, "R11 no window flag", int'(strap_viol), 0);
        rst_req = 1'b0;
        e = 0;
        wait_release(e);
        check(ratio_cfg == 3'd7, "R5 capture after reassert", int'(ratio_cfg), 7);
        // Idle strap changes after window
        step(3);
        ratio_strap = 3'd1; burst_strap = 1'b1; flush_req = 1'b0;
        step(5);
        check(ratio_cfg == 3'd7 && !burst_cfg && flush_cfg, "R7 held while running", int'(ratio_cfg), 7);
        check(strap_viol == 1'b0, "R7 idle change no flag", int'(strap_viol), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule